// File: doc/BRIEF.md
# Block-Cipher Accelerator Register Front-End

This block is the bus-facing register bank that sits in front of a 128-bit block-cipher engine. Software reaches it over an APB slave port with zero wait states. Through it, software loads key material and a data block, picks an operation and a key length, and launches the engine. It then learns of completion either by polling a busy flag or through an active-low level interrupt. The engine datapath is not part of the block: it is seen only as a handshake made of a start pulse out, a done pulse in and a 128-bit result bus in.

The bank holds a control word, a status word, eight write-only key words, four plaintext words and four ciphertext words. When the engine finishes a cipher, its result is stored in the ciphertext words. When it finishes a decipher, the result goes to the plaintext words. A key-expansion run leaves both data sets untouched. The key and its length can come from the registers or from a 256-bit side input. A separate force pin locks the selection to the side input. A clock-request output stays high while there is work in flight or an interrupt is pending, so the surrounding logic may gate the bus clock at all other times.

Top module: `cipher_apb_regs`

## Requirements
- R1: After reset the control word and status word read 0, the data words read 0, irq_n is 1, clk_active_req is 0 and eng_start is 0.
- R2: paddr is a word index (byte offset divided by 4). The map is: 0 control, 1 status, 2..9 key, 10..13 plaintext, 14..17 ciphertext. pready is always 1. In the access phase, pslverr is 1 for any index of 18 or more and for reads of the key words, and such reads return 0.
- R3: The control word layout is: bit 0 enable, bit 1 start, bits 3:2 operation (0 cipher, 1 decipher, 2 key expansion, 3 reserved), bits 5:4 key length (0 128, 1 192, 2 256), bit 6 key source (1 = side input), bit 7 interrupt enable. All fields read back as written, except start. An accepted start makes eng_start high for exactly the one cycle after the write, and start reads 0 afterwards.
- R4: Key word index 2 holds eng_key[31:0] and each following index holds the next 32 bits, up to index 9 for eng_key[255:224].
- R5: The plaintext and ciphertext words are readable and writable, with the lowest index holding bits 31:0 of the block.
- R6: When ext_key_force is 1, or when the source bit is 1, eng_key equals ext_key and eng_key_size equals ext_key_size. Otherwise eng_key and eng_key_size come from the key registers and the length field.
- R7: A start is ignored, with no eng_start and no busy, when the enable bit written with it is 0, when the operation is reserved (3), or when an operation is already in progress.
- R8: Status bit 0 (busy) is set by an accepted start and cleared by eng_done. eng_mode holds the launched operation. On eng_done, a cipher loads eng_result into the ciphertext words, a decipher loads it into the plaintext words, and a key expansion loads neither. An eng_done while not busy has no effect.
- R9: Status bit 1 is set when an operation finishes while the interrupt enable bit is 1, and it stays 0 otherwise. Writing 1 to that bit clears it. irq_n is low exactly while the bit is set.
- R10: clk_active_req is high while busy or while the interrupt status is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Asynchronous active-low reset |
| paddr | input | 6 | Word index of the access |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| pwdata | input | 32 | Write data |
| pready | output | 1 | Always ready |
| prdata | output | 32 | Read data |
| pslverr | output | 1 | Error response for unmapped or write-only reads |
| clk_active_req | output | 1 | Request to keep the clock running |
| ext_key | input | 256 | Key supplied from outside the register bank |
| ext_key_size | input | 2 | Key length code that goes with ext_key |
| ext_key_force | input | 1 | Forces use of ext_key and ext_key_size |
| irq_n | output | 1 | Active-low level interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_mode | output | 2 | Operation of the launched run |
| eng_key_size | output | 2 | Selected key length code |
| eng_key | output | 256 | Selected key |
| eng_block | output | 128 | Ciphertext words for a decipher, plaintext words otherwise |
| eng_done | input | 1 | Completion pulse from the engine |
| eng_result | input | 128 | Result block, valid with eng_done |

## Verification
The assertions assume that the bus master follows the APB protocol, with a setup cycle before every access cycle. They also assume that the engine raises eng_done for single cycles only. The interrupt and start-pulse properties do not depend on eng_done arriving only while busy. This matters because the stimulus deliberately sends one stray completion pulse while the block is idle, and otherwise pulses eng_done only after a launch has been seen. All bus traffic goes through one write task and one read task that keep the two-phase order, and the engine inputs change only on falling clock edges.

// File: rtl/cipher_regs_pkg.sv
package cipher_regs_pkg;

  typedef enum logic [1:0] {
    OP_ENC  = 2'd0,
    OP_DEC  = 2'd1,
    OP_KEXP = 2'd2,
    OP_RSVD = 2'd3
  } op_mode_e;

  // control word bit positions (software-visible layout)
  localparam int CB_EN    = 0;
  localparam int CB_START = 1;
  localparam int CB_MODE  = 2;
  localparam int CB_SIZE  = 4;
  localparam int CB_SRC   = 6;
  localparam int CB_IE    = 7;
  localparam int CTRL_W   = 8;

  // status word bit positions
  localparam int SB_BUSY  = 0;
  localparam int SB_IRQ   = 1;

  // word-index map
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_KEY  = 2;

endpackage

// File: rtl/cipher_rst_sync.sv
module cipher_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/cipher_ctrl_stat.sv
module cipher_ctrl_stat
  import cipher_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              stat_we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              eng_done,
  output logic              en,
  output logic              start_q,
  output op_mode_e          mode,
  output logic [1:0]        size,
  output logic              src,
  output logic              ie,
  output logic              busy,
  output logic              irq_flag,
  output op_mode_e          op_mode,
  output logic              op_done
);

  logic     en_d, start_d, src_d, ie_d, busy_d, irq_d;
  op_mode_e mode_d, op_mode_d, wr_mode;
  logic [1:0] size_d;
  logic     launch;

  assign wr_mode = op_mode_e'(wdata[CB_MODE +: 2]);

  // a launch needs enable set in the same write, a legal operation and an idle engine
  assign launch  = ctrl_we && wdata[CB_START] && wdata[CB_EN] &&
                   !busy && (wr_mode != OP_RSVD);
  assign op_done = eng_done && busy;

  always_comb begin
    en_d      = en;
    mode_d    = mode;
    size_d    = size;
    src_d     = src;
    ie_d      = ie;
    if (ctrl_we) begin
      en_d   = wdata[CB_EN];
      mode_d = wr_mode;
      size_d = wdata[CB_SIZE +: 2];
      src_d  = wdata[CB_SRC];
      ie_d   = wdata[CB_IE];
    end
    start_d   = launch;
    op_mode_d = launch ? wr_mode : op_mode;
    busy_d    = busy;
    if (launch)       busy_d = 1'b1;
    else if (op_done) busy_d = 1'b0;
    // a completion setting the flag wins over a clear in the same cycle
    irq_d = irq_flag;
    if (op_done && ie)                   irq_d = 1'b1;
    else if (stat_we && wdata[SB_IRQ])   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      start_q  <= 1'b0;
      mode     <= OP_ENC;
      size     <= 2'd0;
      src      <= 1'b0;
      ie       <= 1'b0;
      busy     <= 1'b0;
      irq_flag <= 1'b0;
      op_mode  <= OP_ENC;
    end else begin
      en       <= en_d;
      start_q  <= start_d;
      mode     <= mode_d;
      size     <= size_d;
      src      <= src_d;
      ie       <= ie_d;
      busy     <= busy_d;
      irq_flag <= irq_d;
      op_mode  <= op_mode_d;
    end
  end

endmodule

// File: rtl/cipher_data_bank.sv
module cipher_data_bank #(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int BLK_WORDS = 4,
  parameter int unsigned KEY_BASE = 2,
  localparam int unsigned PT_BASE = KEY_BASE + KEY_WORDS,
  localparam int unsigned CT_BASE = PT_BASE + BLK_WORDS,
  localparam int KEY_W = KEY_WORDS * DATA_W,
  localparam int BLK_W = BLK_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap_pt,
  input  logic              cap_ct,
  input  logic [BLK_W-1:0]  result,
  output logic [KEY_W-1:0]  key_flat,
  output logic [BLK_W-1:0]  pt_flat,
  output logic [BLK_W-1:0]  ct_flat
);

  genvar gk;
  generate
    for (gk = 0; gk < KEY_WORDS; gk++) begin : g_key
      logic we_k;
      assign we_k = wr_en && (widx == KEY_BASE + gk);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    key_flat[gk*DATA_W +: DATA_W] <= '0;
        else if (we_k) key_flat[gk*DATA_W +: DATA_W] <= wdata;
      end
    end
  endgenerate

  genvar gb;
  generate
    for (gb = 0; gb < BLK_WORDS; gb++) begin : g_blk
      logic              pt_en, ct_en;
      logic [DATA_W-1:0] pt_d, ct_d;
      // engine capture takes priority over a bus write in the same cycle
      always_comb begin
        pt_en = cap_pt || (wr_en && (widx == PT_BASE + gb));
        ct_en = cap_ct || (wr_en && (widx == CT_BASE + gb));
        pt_d  = cap_pt ? result[gb*DATA_W +: DATA_W] : wdata;
        ct_d  = cap_ct ? result[gb*DATA_W +: DATA_W] : wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pt_flat[gb*DATA_W +: DATA_W] <= '0;
          ct_flat[gb*DATA_W +: DATA_W] <= '0;
        end else begin
          if (pt_en) pt_flat[gb*DATA_W +: DATA_W] <= pt_d;
          if (ct_en) ct_flat[gb*DATA_W +: DATA_W] <= ct_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cipher_apb_regs.sv
module cipher_apb_regs
  import cipher_regs_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int BLK_WORDS = 4,
  localparam int KEY_W = KEY_WORDS * DATA_W,
  localparam int BLK_W = BLK_WORDS * DATA_W,
  localparam int unsigned PT_BASE = IDX_KEY + KEY_WORDS,
  localparam int unsigned CT_BASE = PT_BASE + BLK_WORDS,
  localparam int unsigned IDX_END = CT_BASE + BLK_WORDS
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] pwdata,
  output logic              pready,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  output logic              clk_active_req,
  input  logic [KEY_W-1:0]  ext_key,
  input  logic [1:0]        ext_key_size,
  input  logic              ext_key_force,
  output logic              irq_n,
  output logic              eng_start,
  output logic [1:0]        eng_mode,
  output logic [1:0]        eng_key_size,
  output logic [KEY_W-1:0]  eng_key,
  output logic [BLK_W-1:0]  eng_block,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_result
);

  logic        rst_n;
  logic [31:0] widx;
  logic        acc, wr, rd, is_key, is_unmapped;
  logic        ctrl_en, start_q, ctrl_src, ctrl_ie, busy, irq_flag, op_done;
  op_mode_e    ctrl_mode, op_mode;
  logic [1:0]  ctrl_size;
  logic        ext_sel;
  logic [KEY_W-1:0] key_flat;
  logic [BLK_W-1:0] pt_flat, ct_flat;

  cipher_rst_sync u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  assign widx        = {{(32-ADDR_W){1'b0}}, paddr};
  assign acc         = psel && penable;
  assign wr          = acc && pwrite;
  assign rd          = acc && !pwrite;
  assign is_key      = (widx >= IDX_KEY) && (widx < PT_BASE);
  assign is_unmapped = (widx >= IDX_END);

  assign pready  = 1'b1;
  assign pslverr = acc && (is_unmapped || (!pwrite && is_key));

  cipher_ctrl_stat u_ctrl (
    .clk      (pclk),
    .rst_n    (rst_n),
    .ctrl_we  (wr && (widx == IDX_CTRL)),
    .stat_we  (wr && (widx == IDX_STAT)),
    .wdata    (pwdata[CTRL_W-1:0]),
    .eng_done (eng_done),
    .en       (ctrl_en),
    .start_q  (start_q),
    .mode     (ctrl_mode),
    .size     (ctrl_size),
    .src      (ctrl_src),
    .ie       (ctrl_ie),
    .busy     (busy),
    .irq_flag (irq_flag),
    .op_mode  (op_mode),
    .op_done  (op_done)
  );

  cipher_data_bank #(
    .DATA_W    (DATA_W),
    .KEY_WORDS (KEY_WORDS),
    .BLK_WORDS (BLK_WORDS),
    .KEY_BASE  (IDX_KEY)
  ) u_bank (
    .clk      (pclk),
    .rst_n    (rst_n),
    .wr_en    (wr),
    .widx     (widx),
    .wdata    (pwdata),
    .cap_pt   (op_done && (op_mode == OP_DEC)),
    .cap_ct   (op_done && (op_mode == OP_ENC)),
    .result   (eng_result),
    .key_flat (key_flat),
    .pt_flat  (pt_flat),
    .ct_flat  (ct_flat)
  );

  // key selection: the force pin overrides the software source bit
  assign ext_sel      = ext_key_force || ctrl_src;
  assign eng_key      = ext_sel ? ext_key : key_flat;
  assign eng_key_size = ext_sel ? ext_key_size : ctrl_size;
  assign eng_mode     = op_mode;
  assign eng_start    = start_q;
  assign eng_block    = (op_mode == OP_DEC) ? ct_flat : pt_flat;

  assign irq_n          = !irq_flag;
  assign clk_active_req = busy || irq_flag;

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (widx == IDX_CTRL)
        prdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_ie, ctrl_src, ctrl_size,
                  ctrl_mode, start_q, ctrl_en};
      else if (widx == IDX_STAT)
        prdata = {{(DATA_W-2){1'b0}}, irq_flag, busy};
      for (int i = 0; i < BLK_WORDS; i++) begin
        if (widx == PT_BASE + i) prdata = pt_flat[i*DATA_W +: DATA_W];
        if (widx == CT_BASE + i) prdata = ct_flat[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/cipher_apb_regs_chk.sv
module cipher_apb_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic psel,
  input logic penable,
  input logic pslverr,
  input logic eng_start,
  input logic eng_done,
  input logic irq_n,
  input logic clk_active_req,
  input logic busy
);

  // R3: launch pulse lasts one cycle
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R8: a launch pulse is always accompanied by busy
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  // R7: no launch follows a busy cycle
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !eng_start);

  // R9: the interrupt only falls after a completion pulse
  assert_irq_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(eng_done));

  // R10: a pending interrupt keeps the clock request up
  assert_cactive_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> clk_active_req);

  // R2: error response only in an access phase
  assert_slverr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable));

endmodule

bind cipher_apb_regs cipher_apb_regs_chk u_chk (
  .clk            (pclk),
  .rst_n          (rst_n),
  .psel           (psel),
  .penable        (penable),
  .pslverr        (pslverr),
  .eng_start      (eng_start),
  .eng_done       (eng_done),
  .irq_n          (irq_n),
  .clk_active_req (clk_active_req),
  .busy           (busy)
);

// File: tb/cipher_apb_regs_bench.sv
`timescale 1ns/1ps
module cipher_apb_regs_bench;

  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic [5:0]   paddr = '0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0]  pwdata = '0;
  logic         pready, pslverr, clk_active_req, irq_n, eng_start;
  logic [31:0]  prdata;
  logic [255:0] ext_key = '0;
  logic [1:0]   ext_key_size = 2'd0;
  logic         ext_key_force = 1'b0;
  logic [1:0]   eng_mode, eng_key_size;
  logic [255:0] eng_key;
  logic [127:0] eng_block;
  logic         eng_done = 1'b0;
  logic [127:0] eng_result = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 pclk = ~pclk;  // 250 MHz

  cipher_apb_regs u_cipher_apb_regs (.*);

  // scoreboard
  logic [31:0] exp_d[$];
  logic        exp_e[$];
  string       exp_t[$];
  logic [31:0] obs_d;
  logic        obs_e;
  event        rd_ev;

  always @(rd_ev) begin
    logic [31:0] d; logic e; string t;
    d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_t.pop_front();
    checks++;
    if (obs_d !== d || obs_e !== e) begin
      fails++;
      $display("FAIL %s: read data=%h err=%b expected data=%h err=%b", t, obs_d, obs_e, d, e);
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input int idx, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 6'(idx); pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input int idx, input logic [31:0] d, input logic e, input string tag);
    exp_d.push_back(d); exp_e.push_back(e); exp_t.push_back(tag);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = 6'(idx); penable = 0;
    @(negedge pclk); penable = 1;
    #1 obs_d = prdata; obs_e = pslverr; -> rd_ev;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic engine_finish(input logic [127:0] r);
    @(negedge pclk); eng_result = r; eng_done = 1;
    @(negedge pclk); eng_done = 0;
  endtask

  function automatic logic [31:0] kword(input int i);
    return 32'hA511_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [255:0] ikey;
    logic [127:0] res1, res2, ptv;
    res1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    res2 = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1357_9BDF;
    ptv  = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    ext_key = {8{32'h5EC0_7E57}};
    ext_key_size = 2'd1;
    repeat (3) @(negedge pclk);
    presetn = 1;
    repeat (3) @(negedge pclk);

    // R1 reset state
    apb_read(0, 32'h0, 0, "R1 ctrl reset");
    apb_read(1, 32'h0, 0, "R1 status reset");
    apb_read(10, 32'h0, 0, "R1 plaintext reset");
    chk("R1 irq_n", irq_n, 1);
    chk("R1 clk_active_req", clk_active_req, 0);
    chk("R1 eng_start", eng_start, 0);

    // R2 map errors
    chk("R2 pready", pready, 1);
    apb_read(18, 32'h0, 1, "R2 unmapped 18");
    apb_read(63, 32'h0, 1, "R2 unmapped 63");
    apb_read(2, 32'h0, 1, "R2 key read");

    // R4/R6 key words and selection
    for (int i = 0; i < 8; i++) begin
      apb_write(2 + i, kword(i));
      ikey[i*32 +: 32] = kword(i);
    end
    apb_write(0, 32'h20);
    chk("R4 internal key order", eng_key, ikey);
    chk("R6 internal size", eng_key_size, 2);
    apb_read(0, 32'h20, 0, "R3 ctrl readback");
    apb_write(0, 32'h60);
    chk("R6 src ext key", eng_key, ext_key);
    chk("R6 src ext size", eng_key_size, 1);
    apb_write(0, 32'h20);
    ext_key_force = 1;
    #1 chk("R6 forced ext key", eng_key, ext_key);
    chk("R6 forced ext size", eng_key_size, 1);
    ext_key_force = 0;

    // R5 data words
    for (int i = 0; i < 4; i++) apb_write(10 + i, ptv[i*32 +: 32]);
    apb_write(14, 32'hC0FF_EE00);
    apb_read(11, ptv[63:32], 0, "R5 plaintext readback");
    apb_read(14, 32'hC0FF_EE00, 0, "R5 ciphertext readback");

    // R7 start without enable
    apb_write(0, 32'h02);
    chk("R7 start with en=0", eng_start, 0);
    apb_read(1, 32'h0, 0, "R7 not busy after en=0 start");

    // R3/R8 cipher with interrupt enabled
    apb_write(0, 32'h83);
    chk("R3 start pulse high", eng_start, 1);
    @(negedge pclk);
    chk("R3 start pulse low", eng_start, 0);
    chk("R8 eng_mode cipher", eng_mode, 0);
    chk("R8 eng_block plaintext", eng_block, ptv);
    chk("R10 clk_active busy", clk_active_req, 1);
    apb_read(0, 32'h81, 0, "R3 start bit self-cleared");
    apb_read(1, 32'h1, 0, "R8 busy set");
    apb_write(0, 32'h87);
    chk("R7 start while busy ignored", eng_start, 0);
    apb_write(0, 32'h81);
    engine_finish(res1);
    for (int i = 0; i < 4; i++) apb_read(14 + i, res1[i*32 +: 32], 0, "R8 cipher result in ciphertext");
    apb_read(10, ptv[31:0], 0, "R8 plaintext untouched by cipher");
    apb_read(1, 32'h2, 0, "R9 status done with irq");
    chk("R9 irq_n low", irq_n, 0);
    chk("R10 clk_active irq pending", clk_active_req, 1);
    apb_write(1, 32'h2);
    apb_read(1, 32'h0, 0, "R9 irq cleared");
    chk("R9 irq_n released", irq_n, 1);
    chk("R10 clk_active idle", clk_active_req, 0);

    // R8/R9 decipher with interrupt disabled
    apb_write(0, 32'h07);
    chk("R8 decipher launch", eng_start, 1);
    @(negedge pclk);
    chk("R8 eng_mode decipher", eng_mode, 1);
    chk("R8 eng_block ciphertext", eng_block, res1);
    engine_finish(res2);
    for (int i = 0; i < 4; i++) apb_read(10 + i, res2[i*32 +: 32], 0, "R8 decipher result in plaintext");
    apb_read(14, res1[31:0], 0, "R8 ciphertext untouched by decipher");
    apb_read(1, 32'h0, 0, "R9 no irq when ie=0");
    chk("R9 irq_n stays high", irq_n, 1);

    // R8 key expansion touches no data
    apb_write(0, 32'h0B);
    chk("R8 key expansion launch", eng_start, 1);
    engine_finish(128'h1);
    apb_read(10, res2[31:0], 0, "R8 kexp leaves plaintext");
    apb_read(15, res1[63:32], 0, "R8 kexp leaves ciphertext");
    apb_read(1, 32'h0, 0, "R8 kexp busy cleared");

    // R7 reserved operation
    apb_write(0, 32'h0F);
    chk("R7 reserved op ignored", eng_start, 0);
    apb_read(1, 32'h0, 0, "R7 reserved op not busy");

    // R8 stray done while idle
    apb_write(0, 32'h80);
    engine_finish(128'hFFFF);
    apb_read(14, res1[31:0], 0, "R8 idle done ignored");
    apb_read(1, 32'h0, 0, "R8 idle done no status");

    repeat (2) @(negedge pclk);
    summary();
  end

endmodule